// File: doc/BRIEF.md
# USB Low/Full-Speed Byte Receiver

This block receives a USB low- or full-speed bit stream from a differential pin pair without software stepping each bit. An internal divider produces one sample per bit time; at each sample the engine decodes NRZI, removes stuffed bits, shifts the data bit into a byte least significant bit first and advances a serial CRC chosen at setup. Software touches the block only once per byte.

A one-cycle prime pulse sets the bit time divide, the CRC polynomial code and the idle level of D+, presets the CRC and clears the counters, flags and byte. When eight data bits have been gathered the byte moves to a single-entry buffer and a ready flag rises, which gives software a full byte time to collect it. An SE0 ends the packet; an SE1 or a broken stuffing rule ends it with an error. After either ending the CRC and buffer stay readable and the engine ignores the line until the next prime.

Top module: `usb_rx_byte_engine`

## Requirements
- R1: After reset the engine is idle with rxReady, rxEnd, rxErr and rxOverrun low, rxByte equal to 0x00 and rxCrc equal to 0xFFFF.
- R2: A prime pulse clears rxReady, rxEnd, rxErr, rxOverrun and rxByte, presets rxCrc to 0xFFFF, clears the bit and stuff counters, loads the divide, polynomial code and previous D+ level, and starts sampling.
- R3: While running, the line is sampled once every primeDivide clock cycles (divide at least 1); a J/K sample whose D+ level equals the previous sampled D+ level is data 1, a changed level is data 0 (J is D+ high with D- low, K the reverse).
- R4: Data bits fill the byte least significant bit first; the eighth data bit moves the byte to rxByte and raises rxReady.
- R5: After six consecutive data 1s the next line bit is a stuffed 0, which is dropped: it shifts neither the byte nor the CRC and is not counted, so a byte of 0xFF takes nine line bits.
- R6: If the bit after six consecutive 1s is also a 1, the packet ends with rxEnd and rxErr high and the CRC left as it was.
- R7: An SE0 sample (both pins low) ends the packet with rxEnd high and rxErr low, without changing rxCrc, rxByte or rxReady.
- R8: An SE1 sample (both pins high) ends the packet with rxEnd and rxErr high; rxErr never stands without rxEnd.
- R9: Polynomial code 00 selects the USB 16-bit CRC x^16+x^15+x^2+1, updated per data bit by shifting left with feedback from bit 15; code 11 behaves as code 00.
- R10: Code 01 selects the USB 5-bit CRC x^5+x^2+1 held in rxCrc[4:0], with rxCrc[15:5] keeping the preset ones.
- R11: A read pulse clears rxReady; a byte completing while rxReady is high and no read is present raises rxOverrun, which stays high until the next prime, and the new byte replaces the buffered one.
- R12: Code 10 selects the 16-bit CRC x^16+x^12+x^5+1 with the same shift rule as R9.
- R13: After the packet ends, further line activity changes none of rxCrc, rxByte, rxReady or rxEnd until the next prime.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| lineDp | input | 1 | D+ line level |
| lineDm | input | 1 | D- line level |
| primeValid | input | 1 | One-cycle setup pulse |
| primeDivide | input | DIV_W | Clock cycles per bit time |
| primePoly | input | 2 | CRC polynomial code |
| primeIdleDp | input | 1 | D+ level taken as the previous sample |
| readStrobe | input | 1 | Byte read pulse, clears rxReady |
| rxByte | output | 8 | Buffered received byte |
| rxCrc | output | 16 | Running CRC register |
| rxReady | output | 1 | Buffered byte waiting |
| rxEnd | output | 1 | Packet ended (SE0 or error) |
| rxErr | output | 1 | Packet ended by SE1 or stuffing violation |
| rxOverrun | output | 1 | A byte replaced an unread one |

## Verification
On every cycle the assertions check that the CRC moves only on a sample or a prime, that a prime leaves the flags cleared and the CRC preset, that the end flag holds, that an error always comes with an end, that overrun and ready rise only from the states that permit them, and that an idle engine freezes its outputs. The bit values themselves, the NRZI decoding, stuffed-bit removal, the three polynomials over every byte value and the line-bit timing of a byte can only be shown by the bench's scenarios, which compare the buffered byte and CRC against values computed independently.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  typedef enum logic [1:0] {
    CRC_USB16  = 2'b00,
    CRC_USB5   = 2'b01,
    CRC_CCITT  = 2'b10,
    CRC_ALIAS  = 2'b11
  } crcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // prime: load setup, clear counters
    logic run;     // engine running, timer advances
    logic sample;  // this cycle is a sample point
    logic take;    // accept a valid data bit
    logic drop;    // discard a stuffed bit
    logic commit;  // move completed byte to the buffer
  } rxStrobe_t;

  localparam logic [15:0] POLY_USB16 = 16'h8005;
  localparam logic [15:0] POLY_CCITT = 16'h1021;
  localparam logic [4:0]  POLY_USB5  = 5'h05;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;

endpackage

// File: rtl/usb_rx_crc.sv
module usb_rx_crc
  import usb_rx_pkg::*;
(
  input  logic [15:0] crcIn,
  input  crcSel_e     crcSel,
  input  logic        bitIn,
  output logic [15:0] crcNext
);
  logic fbWide;
  logic fbNarrow;

  always_comb begin
    fbWide   = bitIn ^ crcIn[15];
    fbNarrow = bitIn ^ crcIn[4];
    case (crcSel)
      CRC_USB5:
        crcNext = {crcIn[15:5], {crcIn[3:0], 1'b0} ^ (fbNarrow ? POLY_USB5 : 5'd0)};
      CRC_CCITT:
        crcNext = {crcIn[14:0], 1'b0} ^ (fbWide ? POLY_CCITT : 16'd0);
      default:
        crcNext = {crcIn[14:0], 1'b0} ^ (fbWide ? POLY_USB16 : 16'd0);
    endcase
  end
endmodule

// File: rtl/usb_rx_datapath.sv
module usb_rx_datapath
  import usb_rx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int STUFF_RUN = 6,
  parameter int BYTE_W    = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  rxStrobe_t         strobe,
  input  logic [DIV_W-1:0]  primeDivide,
  input  logic [1:0]        primePoly,
  input  logic              primeIdleDp,
  input  logic              lineDp,
  input  logic              lineDm,
  output logic              timerHit,
  output logic              se0,
  output logic              se1,
  output logic              dataBit,
  output logic              stuffSlot,
  output logic              lastBit,
  output logic [15:0]       crcOut,
  output logic [BYTE_W-1:0] byteOut
);
  localparam int ONES_W = $clog2(STUFF_RUN + 1);
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [DIV_W-1:0]  DIV_ONE  = 1;
  localparam logic [ONES_W-1:0] ONES_MAX = ONES_W'(STUFF_RUN);
  localparam logic [CNT_W-1:0]  CNT_LAST = CNT_W'(BYTE_W - 1);

  logic [DIV_W-1:0]  divReg;
  logic [DIV_W-1:0]  timer;
  crcSel_e           selReg;
  logic              prevDp;
  logic [15:0]       crcReg;
  logic [15:0]       crcNext;
  logic [BYTE_W-2:0] accReg;
  logic [ONES_W-1:0] onesCnt;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] bufReg;

  usb_rx_crc crc_i (
    .crcIn   (crcReg),
    .crcSel  (selReg),
    .bitIn   (dataBit),
    .crcNext (crcNext)
  );

  assign timerHit  = (timer == divReg - DIV_ONE);
  assign se0       = !lineDp && !lineDm;
  assign se1       = lineDp && lineDm;
  assign dataBit   = (lineDp == prevDp);
  assign stuffSlot = (onesCnt == ONES_MAX);
  assign lastBit   = (bitCnt == CNT_LAST);
  assign crcOut    = crcReg;
  assign byteOut   = bufReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divReg  <= DIV_ONE;
      timer   <= '0;
      selReg  <= CRC_USB16;
      prevDp  <= 1'b1;
      crcReg  <= CRC_PRESET;
      accReg  <= '0;
      onesCnt <= '0;
      bitCnt  <= '0;
      bufReg  <= '0;
    end else if (strobe.load) begin
      divReg  <= primeDivide;
      timer   <= '0;
      selReg  <= crcSel_e'(primePoly);
      prevDp  <= primeIdleDp;
      crcReg  <= CRC_PRESET;
      accReg  <= '0;
      onesCnt <= '0;
      bitCnt  <= '0;
      bufReg  <= '0;
    end else begin
      if (strobe.sample)   timer <= '0;
      else if (strobe.run) timer <= timer + DIV_ONE;

      if (strobe.take) begin
        accReg  <= {dataBit, accReg[BYTE_W-2:1]};
        crcReg  <= crcNext;
        bitCnt  <= bitCnt + 1'b1;
        onesCnt <= dataBit ? onesCnt + 1'b1 : '0;
        prevDp  <= lineDp;
        if (strobe.commit) bufReg <= {dataBit, accReg};
      end else if (strobe.drop) begin
        onesCnt <= '0;
        prevDp  <= lineDp;
      end
    end
  end
endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
  import usb_rx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      primeValid,
  input  logic      readStrobe,
  input  logic      timerHit,
  input  logic      se0,
  input  logic      se1,
  input  logic      dataBit,
  input  logic      stuffSlot,
  input  logic      lastBit,
  output rxStrobe_t strobe,
  output logic      active,
  output logic      rxReady,
  output logic      rxEnd,
  output logic      rxErr,
  output logic      rxOverrun
);
  logic sampleNow;
  logic lineOk;
  logic endEop;
  logic endErr;

  always_comb begin
    sampleNow = active && !primeValid && timerHit;
    lineOk    = !se0 && !se1;
    endEop    = sampleNow && se0;
    endErr    = sampleNow && (se1 || (lineOk && stuffSlot && dataBit));

    strobe        = '0;
    strobe.load   = primeValid;
    strobe.run    = active && !primeValid;
    strobe.sample = sampleNow;
    strobe.take   = sampleNow && lineOk && !stuffSlot;
    strobe.drop   = sampleNow && lineOk && stuffSlot && !dataBit;
    strobe.commit = strobe.take && lastBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      rxReady   <= 1'b0;
      rxEnd     <= 1'b0;
      rxErr     <= 1'b0;
      rxOverrun <= 1'b0;
    end else if (primeValid) begin
      active    <= 1'b1;
      rxReady   <= 1'b0;
      rxEnd     <= 1'b0;
      rxErr     <= 1'b0;
      rxOverrun <= 1'b0;
    end else begin
      if (endEop || endErr) begin
        active <= 1'b0;
        rxEnd  <= 1'b1;
        rxErr  <= endErr;
      end
      if (strobe.commit) begin
        rxReady <= 1'b1;
        if (rxReady && !readStrobe) rxOverrun <= 1'b1;
      end else if (readStrobe) begin
        rxReady <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_rx_byte_engine.sv
module usb_rx_byte_engine
  import usb_rx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int STUFF_RUN = 6
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineDp,
  input  logic             lineDm,
  input  logic             primeValid,
  input  logic [DIV_W-1:0] primeDivide,
  input  logic [1:0]       primePoly,
  input  logic             primeIdleDp,
  input  logic             readStrobe,
  output logic [7:0]       rxByte,
  output logic [15:0]      rxCrc,
  output logic             rxReady,
  output logic             rxEnd,
  output logic             rxErr,
  output logic             rxOverrun
);
  rxStrobe_t strobe;
  logic timerHit, se0, se1, dataBit, stuffSlot, lastBit;
  logic engineActive;
  logic sampleTick;

  assign sampleTick = strobe.sample;

  usb_rx_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .primeValid (primeValid),
    .readStrobe (readStrobe),
    .timerHit   (timerHit),
    .se0        (se0),
    .se1        (se1),
    .dataBit    (dataBit),
    .stuffSlot  (stuffSlot),
    .lastBit    (lastBit),
    .strobe     (strobe),
    .active     (engineActive),
    .rxReady    (rxReady),
    .rxEnd      (rxEnd),
    .rxErr      (rxErr),
    .rxOverrun  (rxOverrun)
  );

  usb_rx_datapath #(
    .DIV_W     (DIV_W),
    .STUFF_RUN (STUFF_RUN),
    .BYTE_W    (8)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .primeDivide (primeDivide),
    .primePoly   (primePoly),
    .primeIdleDp (primeIdleDp),
    .lineDp      (lineDp),
    .lineDm      (lineDm),
    .timerHit    (timerHit),
    .se0         (se0),
    .se1         (se1),
    .dataBit     (dataBit),
    .stuffSlot   (stuffSlot),
    .lastBit     (lastBit),
    .crcOut      (rxCrc),
    .byteOut     (rxByte)
  );
endmodule

// File: rtl/usb_rx_byte_engine_chk.sv
module usb_rx_byte_engine_chk (
  input logic        clk,
  input logic        rstN,
  input logic        primeValid,
  input logic        readStrobe,
  input logic        sampleTick,
  input logic        engineActive,
  input logic [7:0]  rxByte,
  input logic [15:0] rxCrc,
  input logic        rxReady,
  input logic        rxEnd,
  input logic        rxErr,
  input logic        rxOverrun
);
  assert_prime_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    primeValid |=> (rxCrc == 16'hFFFF && rxByte == 8'h00 && !rxReady && !rxEnd && !rxErr && !rxOverrun));

  assert_crc_moves_on_sample_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !primeValid) |=> $stable(rxCrc));

  assert_ready_from_running_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> $past(engineActive));

  assert_end_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (rxEnd && !primeValid) |=> rxEnd);

  assert_err_with_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    rxErr |-> rxEnd);

  assert_overrun_needs_ready_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxOverrun) |-> $past(rxReady));

  assert_read_clears_R11: assert property (@(posedge clk) disable iff (!rstN)
    (rxReady && readStrobe && !primeValid && !sampleTick) |=> !rxReady);

  assert_idle_frozen_R13: assert property (@(posedge clk) disable iff (!rstN)
    (!engineActive && !primeValid) |=> ($stable(rxCrc) && $stable(rxByte) && !$rose(rxReady)));
endmodule

bind usb_rx_byte_engine usb_rx_byte_engine_chk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .primeValid   (primeValid),
  .readStrobe   (readStrobe),
  .sampleTick   (sampleTick),
  .engineActive (engineActive),
  .rxByte       (rxByte),
  .rxCrc        (rxCrc),
  .rxReady      (rxReady),
  .rxEnd        (rxEnd),
  .rxErr        (rxErr),
  .rxOverrun    (rxOverrun)
);

// File: tb/usb_rx_byte_engine_tb.sv
`timescale 1ns/1ps
module usb_rx_byte_engine_tb_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lineDp = 1'b1;
  logic        lineDm = 1'b0;
  logic        primeValid = 1'b0;
  logic [7:0]  primeDivide = 8'(DIV);
  logic [1:0]  primePoly = 2'b00;
  logic        primeIdleDp = 1'b1;
  logic        readStrobe = 1'b0;
  logic [7:0]  rxByte;
  logic [15:0] rxCrc;
  logic        rxReady, rxEnd, rxErr, rxOverrun;

  int tests = 0;
  int fails = 0;
  int onesRun = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  usb_rx_byte_engine dut_i (
    .clk(clk), .rstN(rstN), .lineDp(lineDp), .lineDm(lineDm),
    .primeValid(primeValid), .primeDivide(primeDivide), .primePoly(primePoly),
    .primeIdleDp(primeIdleDp), .readStrobe(readStrobe),
    .rxByte(rxByte), .rxCrc(rxCrc), .rxReady(rxReady), .rxEnd(rxEnd),
    .rxErr(rxErr), .rxOverrun(rxOverrun)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crcBit(logic [15:0] c, logic b, logic [1:0] p);
    logic fb;
    if (p == 2'b01) begin
      fb = b ^ c[4];
      c[4:0] = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
    end else begin
      fb = b ^ c[15];
      c = {c[14:0], 1'b0} ^ (fb ? ((p == 2'b10) ? 16'h1021 : 16'h8005) : 16'h0000);
    end
    return c;
  endfunction

  function automatic logic [15:0] crcByte(logic [15:0] c, logic [7:0] v, logic [1:0] p);
    for (int i = 0; i < 8; i++) c = crcBit(c, v[i], p);
    return c;
  endfunction

  task automatic window();
    repeat (DIV) @(negedge clk);
  endtask

  task automatic prime(input logic [1:0] p);
    primePoly = p;
    primeValid = 1'b1;
    lineDp = 1'b1;
    lineDm = 1'b0;
    @(negedge clk);
    primeValid = 1'b0;
    onesRun = 0;
  endtask

  task automatic sendJK(input logic dp);
    lineDp = dp;
    lineDm = !dp;
    window();
  endtask

  task automatic sendLevel(input logic dp, input logic dm);
    lineDp = dp;
    lineDm = dm;
    window();
  endtask

  task automatic sendBit(input logic b);
    if (onesRun == 6) begin
      sendJK(!lineDp);
      onesRun = 0;
    end
    if (b) begin
      sendJK(lineDp);
      onesRun++;
    end else begin
      sendJK(!lineDp);
      onesRun = 0;
    end
  endtask

  task automatic sendByte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) sendBit(v[i]);
  endtask

  task automatic readPulse();
    readStrobe = 1'b1;
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] expCrc;
    string tag;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'd0, rxReady}, 0);
    check("R1 end", {31'd0, rxEnd}, 0);
    check("R1 crc", {16'd0, rxCrc}, 32'hFFFF);
    check("R1 byte", {24'd0, rxByte}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 R4: 0x80 = seven line changes then one hold
    prime(2'b00);
    for (int i = 0; i < 7; i++) sendBit(1'b0);
    check("R3 no byte after 7 bits", {31'd0, rxReady}, 0);
    sendBit(1'b1);
    check("R4 ready after 8 bits", {31'd0, rxReady}, 1);
    check("R3 R4 byte 0x80", {24'd0, rxByte}, 32'h80);
    readPulse();
    check("R11 read clears ready", {31'd0, rxReady}, 0);

    // Sweep every byte value under every polynomial code
    for (int p = 0; p < 4; p++) begin
      tag = (p == 1) ? "R10" : (p == 2) ? "R12" : "R9";
      for (int v = 0; v < 256; v++) begin
        prime(2'(p));
        sendByte(8'(v));
        expCrc = crcByte(16'hFFFF, 8'(v), 2'(p));
        check({"R4 ready ", tag}, {31'd0, rxReady}, 1);
        check({"R4 byte ", tag}, {24'd0, rxByte}, {24'd0, 8'(v)});
        check({"crc ", tag}, {16'd0, rxCrc}, {16'd0, expCrc});
      end
    end

    // R5: 0xFF needs nine line bits
    prime(2'b00);
    for (int i = 0; i < 7; i++) sendBit(1'b1);
    check("R5 no byte after 8 line bits", {31'd0, rxReady}, 0);
    sendBit(1'b1);
    check("R5 ready after 9 line bits", {31'd0, rxReady}, 1);
    check("R5 byte 0xFF", {24'd0, rxByte}, 32'hFF);
    check("R5 crc skips stuff", {16'd0, rxCrc}, {16'd0, crcByte(16'hFFFF, 8'hFF, 2'b00)});

    // R11 overrun
    prime(2'b00);
    sendByte(8'h12);
    sendByte(8'h34);
    check("R11 overrun set", {31'd0, rxOverrun}, 1);
    check("R11 newest byte kept", {24'd0, rxByte}, 32'h34);
    readPulse();
    check("R11 ready cleared", {31'd0, rxReady}, 0);
    check("R11 overrun sticky", {31'd0, rxOverrun}, 1);

    // R2 prime clears
    prime(2'b10);
    check("R2 overrun cleared", {31'd0, rxOverrun}, 0);
    check("R2 byte cleared", {24'd0, rxByte}, 0);
    check("R2 crc preset", {16'd0, rxCrc}, 32'hFFFF);

    // R7 SE0 end, R13 frozen afterwards
    prime(2'b00);
    sendByte(8'hA5);
    readPulse();
    sendBit(1'b0);
    sendBit(1'b1);
    expCrc = crcBit(crcBit(crcByte(16'hFFFF, 8'hA5, 2'b00), 1'b0, 2'b00), 1'b1, 2'b00);
    sendLevel(1'b0, 1'b0);
    check("R7 end set", {31'd0, rxEnd}, 1);
    check("R7 no error", {31'd0, rxErr}, 0);
    check("R7 crc kept", {16'd0, rxCrc}, {16'd0, expCrc});
    check("R7 byte kept", {24'd0, rxByte}, 32'hA5);
    sendByte(8'h3C);
    sendByte(8'hC3);
    check("R13 crc frozen", {16'd0, rxCrc}, {16'd0, expCrc});
    check("R13 byte frozen", {24'd0, rxByte}, 32'hA5);
    check("R13 no ready", {31'd0, rxReady}, 0);
    check("R13 end held", {31'd0, rxEnd}, 1);

    // R8 SE1
    prime(2'b01);
    sendBit(1'b0);
    sendBit(1'b1);
    sendLevel(1'b1, 1'b1);
    check("R8 end", {31'd0, rxEnd}, 1);
    check("R8 error", {31'd0, rxErr}, 1);

    // R6 stuffing violation
    prime(2'b00);
    for (int i = 0; i < 6; i++) sendBit(1'b1);
    expCrc = 16'hFFFF;
    for (int i = 0; i < 6; i++) expCrc = crcBit(expCrc, 1'b1, 2'b00);
    sendJK(lineDp);
    check("R6 end", {31'd0, rxEnd}, 1);
    check("R6 error", {31'd0, rxErr}, 1);
    check("R6 crc kept", {16'd0, rxCrc}, {16'd0, expCrc});

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule